// File: doc/BRIEF.md
# Conversion Pacer and Trigger Controller

This block issues start-of-conversion pulses to an analog-to-digital converter. A pulse can come from a software strobe, from a down-counter clocked by an internal time-base tick, from two down-counters chained so that the upper one counts terminal counts of the lower one, or from falling edges of an external pacer clock. A digital trigger input can serve as a one-shot arming trigger (rising edge) or as a level gate. Every mode setting and reload value is captured at the moment the master enable is set, and nothing paces until then. A busy flag follows each conversion from its start pulse until the converter reports completion.

The controller is built around three states. `ST_OFF` is the disarmed state. `ST_WAIT` means armed and waiting for a trigger edge. `ST_PACE` means pacing. The transitions are:
- `ST_OFF -> ST_WAIT` when enabled with trigger qualification.
- `ST_OFF -> ST_PACE` when enabled with any other qualification.
- `ST_WAIT -> ST_PACE` on a synchronized trigger rising edge.
- `ST_WAIT -> ST_OFF` and `ST_PACE -> ST_OFF` when the enable is cleared.

Both external inputs pass through a two-flop synchronizer before edge detection. On `ST_OFF -> ST_PACE` and on `ST_WAIT -> ST_PACE`, the counters and the time-base prescaler load fresh values.

Top module: `conv_pacer`

## Requirements
- R1: After reset, `soc`, `busy` and `trig_seen` are all 0.
- R2: While `pace_en` is 0, no `soc` pulse is produced. `src_sel` (0 software, 1 single counter, 2 chained counters, 3 external clock), `qual_sel` (0 none, 1 trigger, 2 gate, 3 none), `lo_reload` and `hi_reload` are captured on the clock where `pace_en` is first seen set.
- R3: In software mode with no qualification, `sw_start` sampled high on a clock edge makes `soc` high for exactly the cycle after that edge.
- R4: In single-counter mode, with no conversion in progress at each terminal count, `soc` pulses repeat every `lo_reload * TICK_DIV` clocks.
- R5: In chained mode, the upper counter decrements once per terminal count of the lower counter, and `soc` pulses repeat every `lo_reload * hi_reload * TICK_DIV` clocks.
- R6: In external-clock mode, each falling edge of `ext_clk` gives exactly one `soc` pulse and a rising edge gives none, so the pulse period equals the `ext_clk` period.
- R7: With trigger qualification, no `soc` occurs and `trig_seen` stays 0 until a rising edge on `trig_in`. After that edge, `trig_seen` is 1 and pacing runs at the programmed period.
- R8: With gate qualification, no `soc` occurs while `trig_in` is low, and the counters hold their count. Pacing resumes while it is high.
- R9: `busy` rises together with each `soc` and stays 1 until `conv_done` is sampled high. It is 0 on the following cycle.
- R10: A pace event that arrives while `busy` is 1 is dropped and produces no `soc`.
- R11: Changes to `src_sel`, `qual_sel`, `lo_reload` or `hi_reload` while `pace_en` stays set have no effect on pacing.
- R12: Clearing `pace_en` clears `trig_seen` on the next cycle and stops all `soc` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pace_en | input | 1 | Master enable; mode is captured when it is set |
| src_sel | input | 2 | Pace source select |
| qual_sel | input | 2 | Qualification select |
| lo_reload | input | CNT_W | Reload value of the lower counter |
| hi_reload | input | CNT_W | Reload value of the upper counter |
| sw_start | input | 1 | Synchronous software start strobe |
| ext_clk | input | 1 | Asynchronous external pacer clock |
| trig_in | input | 1 | Asynchronous trigger or gate input |
| conv_done | input | 1 | Converter completion pulse |
| soc | output | 1 | Start-of-conversion pulse |
| busy | output | 1 | Conversion in progress |
| trig_seen | output | 1 | Trigger edge has occurred since arming |

## Verification
The assertions assume that `conv_done` is pulsed only while `busy` is 1, and that each pulse lasts one cycle. The bench's converter model answers each `soc` after a fixed three-cycle delay, and every programmed pacing period is longer than that delay, so no event is dropped except in the dedicated overrun test. The assertions also assume that `sw_start` is a one-cycle strobe and that the external inputs hold each level for many clocks. The bench drives `sw_start` for single cycles and toggles `ext_clk` and `trig_in` at intervals of ten or more clocks.

// File: rtl/conv_pacer_pkg.sv
package conv_pacer_pkg;

    typedef enum logic [1:0] {
        SRC_SW      = 2'd0,
        SRC_TIMER   = 2'd1,
        SRC_CASCADE = 2'd2,
        SRC_EXTCLK  = 2'd3
    } pace_src_e;

    typedef enum logic [1:0] {
        QUAL_NONE  = 2'd0,
        QUAL_TRIG  = 2'd1,
        QUAL_GATE  = 2'd2,
        QUAL_NONE2 = 2'd3
    } qual_e;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_WAIT = 2'd1,
        ST_PACE = 2'd2
    } pace_state_e;

endpackage

// File: rtl/conv_sync.sv
module conv_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic lvl_o,
    output logic prev_o
);
    logic [STAGES:0] sr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= {sr_q[STAGES-1:0], async_i};
    end

    assign lvl_o  = sr_q[STAGES-1];
    assign prev_o = sr_q[STAGES];
endmodule

// File: rtl/conv_tick_gen.sv
module conv_tick_gen #(
    parameter int TICK_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [W-1:0] LAST = W'(TICK_DIV - 1);

    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clear) cnt_q <= '0;
        else if (run)   cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
endmodule

// File: rtl/conv_down_ctr.sv
module conv_down_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             en,
    output logic             tc
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    assign tc = en && (cnt_q == ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (load) cnt_q <= load_val;
        else if (en)   cnt_q <= (cnt_q == ONE) ? reload_val : cnt_q - 1'b1;
    end
endmodule

// File: rtl/conv_pacer.sv
module conv_pacer
    import conv_pacer_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int TICK_DIV = 4,
    parameter int SYNC_STG = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pace_en,
    input  logic [1:0]       src_sel,
    input  logic [1:0]       qual_sel,
    input  logic [CNT_W-1:0] lo_reload,
    input  logic [CNT_W-1:0] hi_reload,
    input  logic             sw_start,
    input  logic             ext_clk,
    input  logic             trig_in,
    input  logic             conv_done,
    output logic             soc,
    output logic             busy,
    output logic             trig_seen
);
    localparam int NCTR = 2;

    pace_state_e state_q, state_d;
    pace_src_e   cfg_src_q;
    qual_e       cfg_qual_q;
    logic [CNT_W-1:0] reload_q [NCTR];
    logic [CNT_W-1:0] reload_in [NCTR];

    logic ext_lvl, ext_prev, trig_lvl, trig_prev;
    logic ext_fall, trig_rise;
    logic arming, ctr_load, run_go, tick, pace_evt;
    logic [NCTR-1:0] ctr_en, ctr_tc;
    logic soc_q, busy_q, trig_seen_q;

    conv_sync #(.STAGES(SYNC_STG)) u_sync_ext (
        .clk(clk), .rst_n(rst_n), .async_i(ext_clk), .lvl_o(ext_lvl), .prev_o(ext_prev)
    );
    conv_sync #(.STAGES(SYNC_STG)) u_sync_trig (
        .clk(clk), .rst_n(rst_n), .async_i(trig_in), .lvl_o(trig_lvl), .prev_o(trig_prev)
    );

    assign ext_fall  = ext_prev & ~ext_lvl;
    assign trig_rise = trig_lvl & ~trig_prev;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:  if (pace_en) state_d = (qual_sel == QUAL_TRIG) ? ST_WAIT : ST_PACE;
            ST_WAIT: if (!pace_en)     state_d = ST_OFF;
                     else if (trig_rise) state_d = ST_PACE;
            ST_PACE: if (!pace_en) state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    assign arming   = (state_q == ST_OFF) && pace_en;
    assign ctr_load = arming || ((state_q == ST_WAIT) && pace_en && trig_rise);
    assign run_go   = (state_q == ST_PACE) && ((cfg_qual_q != QUAL_GATE) || trig_lvl);

    conv_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .clear(ctr_load), .run(run_go), .tick(tick)
    );

    assign reload_in[0] = lo_reload;
    assign reload_in[1] = hi_reload;

    // Counter chain: stage 0 counts ticks, stage 1 counts stage 0 terminal counts
    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        if (g == 0) begin : g_first
            assign ctr_en[g] = tick && ((cfg_src_q == SRC_TIMER) || (cfg_src_q == SRC_CASCADE));
        end else begin : g_next
            assign ctr_en[g] = ctr_tc[g-1] && (cfg_src_q == SRC_CASCADE);
        end
        conv_down_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk(clk), .rst_n(rst_n), .load(ctr_load),
            .load_val(arming ? reload_in[g] : reload_q[g]),
            .reload_val(reload_q[g]),
            .en(ctr_en[g]), .tc(ctr_tc[g])
        );
    end

    always_comb begin
        unique case (cfg_src_q)
            SRC_SW:      pace_evt = sw_start && run_go;
            SRC_TIMER:   pace_evt = ctr_tc[0];
            SRC_CASCADE: pace_evt = ctr_tc[NCTR-1];
            SRC_EXTCLK:  pace_evt = ext_fall && run_go;
            default:     pace_evt = 1'b0;
        endcase
    end

    // Registered outputs and captured configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soc_q       <= 1'b0;
            busy_q      <= 1'b0;
            trig_seen_q <= 1'b0;
            cfg_src_q   <= SRC_SW;
            cfg_qual_q  <= QUAL_NONE;
            for (int i = 0; i < NCTR; i++) reload_q[i] <= '0;
        end else begin
            if (arming) begin
                cfg_src_q  <= pace_src_e'(src_sel);
                cfg_qual_q <= qual_e'(qual_sel);
                for (int i = 0; i < NCTR; i++) reload_q[i] <= reload_in[i];
            end
            soc_q <= pace_evt && !busy_q;
            if (pace_evt && !busy_q) busy_q <= 1'b1;
            else if (conv_done)      busy_q <= 1'b0;
            if (!pace_en)                                  trig_seen_q <= 1'b0;
            else if ((state_q == ST_WAIT) && trig_rise)    trig_seen_q <= 1'b1;
        end
    end

    assign soc       = soc_q;
    assign busy      = busy_q;
    assign trig_seen = trig_seen_q;
endmodule

// File: rtl/conv_pacer_chk.sv
module conv_pacer_chk (
    input logic clk,
    input logic rst_n,
    input logic pace_en,
    input logic conv_done,
    input logic soc,
    input logic busy,
    input logic trig_seen
);
    p_soc_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pace_en && $past(!pace_en)) |-> !soc);

    p_soc_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        soc |=> !soc);

    p_busy_with_soc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        soc |-> busy);

    p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_done) |=> busy);

    p_busy_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_done) |=> !busy);

    p_soc_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        soc |-> !$past(busy));

    p_trig_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !pace_en |=> !trig_seen);
endmodule

bind conv_pacer conv_pacer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pace_en(pace_en), .conv_done(conv_done),
    .soc(soc), .busy(busy), .trig_seen(trig_seen)
);

// File: tb/conv_pacer_tb_top.sv
module conv_pacer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;
    localparam int TICK_DIV   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pace_en = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [1:0] qual_sel = 2'd0;
    logic [CNT_W-1:0] lo_reload = '0;
    logic [CNT_W-1:0] hi_reload = '0;
    logic sw_start = 1'b0;
    logic ext_clk = 1'b0;
    logic trig_in = 1'b0;
    logic adc_pulse = 1'b0;
    logic man_done = 1'b0;
    logic conv_done;
    logic soc, busy, trig_seen;

    assign conv_done = adc_pulse | man_done;

    conv_pacer #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .pace_en(pace_en), .src_sel(src_sel),
        .qual_sel(qual_sel), .lo_reload(lo_reload), .hi_reload(hi_reload),
        .sw_start(sw_start), .ext_clk(ext_clk), .trig_in(trig_in),
        .conv_done(conv_done), .soc(soc), .busy(busy), .trig_seen(trig_seen)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int soc_total = 0;
    int exp_q[$];
    bit mon_on = 1'b0;
    bit have_prev = 1'b0;
    int prev_cyc = 0;
    string mon_req = "";
    bit adc_auto = 1'b1;
    int adc_cnt = 0;
    bit ext_run = 1'b0;
    bit done = 1'b0;

    always @(posedge clk) cyc++;

    // Converter model: completion three cycles after each start
    always @(negedge clk) begin
        adc_pulse = 1'b0;
        if (adc_cnt > 0) begin
            adc_cnt--;
            if (adc_cnt == 0) adc_pulse = 1'b1;
        end else if (adc_auto && soc) adc_cnt = 3;
    end

    // External pacer clock source
    initial forever begin
        repeat (15) @(negedge clk);
        if (ext_run) ext_clk = ~ext_clk;
    end

    // Monitor: compares intervals between start pulses with expected items
    always @(negedge clk) begin
        if (soc) begin
            soc_total++;
            if (mon_on) begin
                if (have_prev) begin
                    n_cmp++;
                    if (exp_q.size() == 0) begin
                        n_bad++;
                        $display("FAIL %s unexpected soc interval actual=%0d expected=none",
                                 mon_req, cyc - prev_cyc);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        if (cyc - prev_cyc != e) begin
                            n_bad++;
                            $display("FAIL %s soc interval actual=%0d expected=%0d",
                                     mon_req, cyc - prev_cyc, e);
                        end
                    end
                end
                prev_cyc  = cyc;
                have_prev = 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_sb(input string req, input int per, input int k);
        mon_req   = req;
        have_prev = 1'b0;
        for (int i = 0; i < k; i++) exp_q.push_back(per);
        mon_on = 1'b1;
        for (int i = 0; i < per * (k + 2) + 100; i++) begin
            if (exp_q.size() == 0) break;
            @(negedge clk);
        end
        mon_on = 1'b0;
        if (exp_q.size() != 0) begin
            check(1'b0, {req, " pending intervals"}, exp_q.size(), 0);
            exp_q.delete();
        end
    endtask

    task automatic arm(input int src, input int qual, input int lo, input int hi);
        @(negedge clk);
        src_sel   = 2'(src);
        qual_sel  = 2'(qual);
        lo_reload = CNT_W'(lo);
        hi_reload = CNT_W'(hi);
        pace_en   = 1'b1;
    endtask

    task automatic disarm();
        @(negedge clk);
        pace_en = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    task automatic sw_pulse();
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
    endtask

    initial begin
        int base;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(soc == 1'b0, "R1 soc", soc, 0);
        check(busy == 1'b0, "R1 busy", busy, 0);
        check(trig_seen == 1'b0, "R1 trig_seen", trig_seen, 0);

        // R2 no pacing while disabled
        src_sel = 2'd1; lo_reload = 16'd2;
        base = soc_total;
        sw_pulse();
        repeat (60) @(negedge clk);
        check(soc_total == base, "R2 soc while disabled", soc_total - base, 0);

        // R3, R9, R10 software start with manual completion
        adc_auto = 1'b0;
        arm(0, 0, 5, 1);
        @(negedge clk);
        sw_pulse();
        check(soc == 1'b1, "R3 soc after sw_start", soc, 1);
        check(busy == 1'b1, "R9 busy with soc", busy, 1);
        @(negedge clk);
        check(soc == 1'b0, "R3 soc one cycle", soc, 0);
        repeat (5) @(negedge clk);
        check(busy == 1'b1, "R9 busy held", busy, 1);
        base = soc_total;
        sw_pulse();
        check(soc == 1'b0, "R10 start dropped while busy", soc, 0);
        repeat (3) @(negedge clk);
        check(soc_total == base, "R10 no soc while busy", soc_total - base, 0);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        check(busy == 1'b0, "R9 busy cleared by conv_done", busy, 0);
        sw_pulse();
        check(soc == 1'b1, "R3 soc after busy clears", soc, 1);
        man_done = 1'b1;
        @(negedge clk);
        man_done = 1'b0;
        adc_auto = 1'b1;
        disarm();

        // R4 single counter, two reload values
        arm(1, 0, 5, 1);
        run_sb("R4 period 5", 5 * TICK_DIV, 3);
        disarm();
        arm(1, 0, 7, 1);
        run_sb("R4 period 7", 7 * TICK_DIV, 3);
        // R11 mode changes while enabled are ignored
        @(negedge clk);
        src_sel = 2'd0; qual_sel = 2'd2; lo_reload = 16'd9;
        run_sb("R11 changes ignored", 7 * TICK_DIV, 3);
        disarm();

        // R5 chained counters
        arm(2, 0, 3, 4);
        run_sb("R5 cascade", 3 * 4 * TICK_DIV, 3);
        disarm();

        // R6 external clock, falling edges only
        ext_run = 1'b1;
        arm(3, 0, 1, 1);
        run_sb("R6 external clock", 30, 3);
        disarm();
        ext_run = 1'b0;

        // R7 trigger qualification
        trig_in = 1'b0;
        arm(1, 1, 5, 1);
        base = soc_total;
        repeat (100) @(negedge clk);
        check(soc_total == base, "R7 no soc before trigger", soc_total - base, 0);
        check(trig_seen == 1'b0, "R7 trig_seen before", trig_seen, 0);
        trig_in = 1'b1;
        repeat (10) @(negedge clk);
        check(trig_seen == 1'b1, "R7 trig_seen after", trig_seen, 1);
        run_sb("R7 pacing after trigger", 5 * TICK_DIV, 3);
        // R12 disable
        @(negedge clk);
        pace_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(trig_seen == 1'b0, "R12 trig_seen cleared", trig_seen, 0);
        base = soc_total;
        repeat (60) @(negedge clk);
        check(soc_total == base, "R12 no soc after disable", soc_total - base, 0);
        trig_in = 1'b0;
        repeat (10) @(negedge clk);

        // R8 gate qualification
        arm(1, 2, 3, 1);
        base = soc_total;
        repeat (80) @(negedge clk);
        check(soc_total == base, "R8 no soc while gate low", soc_total - base, 0);
        trig_in = 1'b1;
        repeat (60) @(negedge clk);
        check(soc_total > base, "R8 soc while gate high", soc_total - base, 4);
        run_sb("R8 gated period", 3 * TICK_DIV, 2);
        trig_in = 1'b0;
        repeat (10) @(negedge clk);
        base = soc_total;
        repeat (60) @(negedge clk);
        check(soc_total == base, "R8 stalled after gate low", soc_total - base, 0);
        disarm();

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule